// File: doc/BRIEF.md
# Descriptor-Chained Transfer Controller

This block serves one activation at a time. An activation carries the index of the source that raised it. The controller first reads a vector word at `VEC_BASE + 4*index`. That word holds the address of the first transfer descriptor. The controller then fetches the four descriptor words, moves one 32-bit word from the source address to the destination address, and writes the updated address and count words back into the descriptor.

After the write-back it takes one of three actions:
- load the next descriptor, which sits 16 bytes further on;
- end the activation with a processor interrupt pulse;
- end the activation with a pulse that clears the request flag of the activating source.

Which action it takes depends on the descriptor's mode bits, its count and a global input that enables chaining in repeat mode. All memory traffic goes over one single-port bus with a req/ack handshake.

Descriptor layout, in 32-bit words from the descriptor address:

| Word | Content |
|------|---------|
| 0 | source address |
| 1 | destination address |
| 2 | count in bits 15:0, repeat reload value in bits 31:16 |
| 3 | mode word |

Mode word bits:

| Bit | Meaning |
|-----|---------|
| 0 | chain |
| 1 | conditional chain |
| 2 | interrupt select |
| 3 | repeat mode |
| 4 | source increment |
| 5 | destination increment |
| 6 | repeat area is the destination (0: the source) |

Top module: `chain_xfer_ctrl`

## Requirements
- R1: After an activation, the first bus access is a read of `VEC_BASE + 4*act_src`. The returned word is the descriptor address, and words 0 to 3 are read from that address and the next three word addresses.
- R2: Each descriptor moves one word: it reads the source address and writes the value read to the destination address. An address whose increment bit (bit 4 for the source, bit 5 for the destination) is set advances by 4; an address whose bit is clear stays unchanged.
- R3: The count decrements by 1 per transfer. Words 0, 1 and 2 are written back with the updated values, and the mode word is never written. This write-back happens before the next descriptor is read and before the outcome pulse.
- R4: With chain=1 and conditional=0, the controller always goes on to the descriptor 16 bytes further on. That descriptor gives no interrupt and no flag clear of its own.
- R5: With chain=1 and conditional=1 in normal mode, the controller chains when the count has just reached zero.
- R6: With chain=1 and conditional=1 and a nonzero remaining count, the activation ends. It ends with an interrupt if interrupt select=1, otherwise with a flag clear, and later descriptors are not touched.
- R7: A normal-mode descriptor with chain=0 ends the activation. If the count reached zero it ends with an interrupt. If the count is nonzero it ends with an interrupt when interrupt select=1, otherwise with a flag clear.
- R8: In repeat mode, when the count reaches zero it is reloaded from bits 31:16. The repeat-area address, if its increment bit is set, is restored to the address it held reload-1 transfers back (post-increment value minus 4*reload). Reaching zero alone gives no interrupt.
- R9: In repeat mode with chain=1 and conditional=1, the controller chains after the transfer in which the count was 1 only if `repeat_chain_en`=1. Otherwise the activation ends as selected by interrupt select.
- R10: `busy` rises the cycle after an accepted activation and stays high through exactly one outcome cycle. In that cycle exactly one of `irq_pulse` and `flag_clr_pulse` is high, and `flag_clr_src` gives the activating source. `busy` is low on the next cycle.
- R11: A request holds `mem_req`, address, write enable and write data stable until `mem_ack`. Only one access is in flight, so a single unchained descriptor costs exactly 10 bus accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| act_valid | input | 1 | activation request, one cycle, accepted when idle |
| act_src | input | SRC_W | index of the activating source |
| repeat_chain_en | input | 1 | global enable for chaining in repeat mode |
| mem_req | output | 1 | bus access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | byte address of the access |
| mem_wdata | output | 32 | write data |
| mem_ack | input | 1 | access complete; read data valid |
| mem_rdata | input | 32 | read data |
| busy | output | 1 | activation in progress |
| irq_pulse | output | 1 | one-cycle processor interrupt |
| flag_clr_pulse | output | 1 | one-cycle clear of the source request flag |
| flag_clr_src | output | SRC_W | source index for the outcome pulses |

## Verification
Every result here arrives only after a variable number of handshaked bus accesses, so no result is sampled at a fixed cycle offset. Each scenario waits on negative edges until `busy` falls, with a bound on the wait. Only then does it read memory and the outcome counters, which were captured at the rising edge of the single outcome cycle. `busy` is checked one cycle after the activation edge. Bus access counts and the stability of held requests are collected edge by edge by a monitor, so the exact cost of 10 accesses per unchained descriptor is checked against the handshake itself.

// File: rtl/cx_pkg.sv
package cx_pkg;

    localparam int WORD_W    = 32;
    localparam int CNT_W     = 16;
    localparam int DESC_WDS  = 4;
    localparam int WB_WDS    = 3;
    localparam logic [WORD_W-1:0] ADDR_STEP = 32'd4;
    localparam logic [WORD_W-1:0] DESC_SPAN = 32'd16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VEC,
        ST_DESC,
        ST_SRD,
        ST_DWR,
        ST_WB,
        ST_NEXT,
        ST_OUT
    } cx_state_e;

    // bit 0 = chain ... bit 6 = repeat area on destination
    typedef struct packed {
        logic rpt_dst;
        logic dst_inc;
        logic src_inc;
        logic rpt;
        logic int_sel;
        logic cond;
        logic chain;
    } cx_mode_t;

    typedef struct packed {
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [CNT_W-1:0]  reload;
        logic [CNT_W-1:0]  count;
        cx_mode_t          mode;
    } cx_desc_t;

    typedef struct packed {
        logic chain;
        logic irq;
        logic clr;
    } cx_outcome_t;

    function automatic cx_outcome_t cx_decide(cx_mode_t m, logic [CNT_W-1:0] cnt_old,
                                              logic rchain_en);
        cx_outcome_t o;
        logic        last;
        last    = (cnt_old == 16'd1);
        o.chain = m.chain & (~m.cond | (last & (~m.rpt | rchain_en)));
        o.irq   = ~o.chain & ((~m.rpt & last) | m.int_sel);
        o.clr   = ~o.chain & ~o.irq;
        return o;
    endfunction

    function automatic cx_desc_t cx_advance(cx_desc_t d);
        cx_desc_t          r;
        logic [WORD_W-1:0] span;
        r    = d;
        span = {14'd0, d.reload, 2'b00};
        if (d.mode.src_inc) r.src = d.src + ADDR_STEP;
        if (d.mode.dst_inc) r.dst = d.dst + ADDR_STEP;
        r.count = d.count - 16'd1;
        if (d.mode.rpt && d.count == 16'd1) begin
            r.count = d.reload;
            if (d.mode.rpt_dst) begin
                if (d.mode.dst_inc) r.dst = r.dst - span;
            end else begin
                if (d.mode.src_inc) r.src = r.src - span;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/cx_desc_store.sv
module cx_desc_store
    import cx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [1:0]        load_idx,
    input  logic [WORD_W-1:0] load_word,
    input  logic              upd_en,
    output cx_desc_t          desc
);

    cx_desc_t desc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            desc_q <= '0;
        end else if (upd_en) begin
            desc_q <= cx_advance(desc_q);
        end else if (load_en) begin
            case (load_idx)
                2'd0:    desc_q.src  <= load_word;
                2'd1:    desc_q.dst  <= load_word;
                2'd2:    begin
                    desc_q.reload <= load_word[31:16];
                    desc_q.count  <= load_word[15:0];
                end
                default: desc_q.mode <= cx_mode_t'(load_word[6:0]);
            endcase
        end
    end

    assign desc = desc_q;

endmodule

// File: rtl/cx_outcome.sv
module cx_outcome
    import cx_pkg::*;
(
    input  cx_desc_t    desc,
    input  logic        rchain_en,
    output cx_outcome_t outcome
);

    always_comb begin
        outcome = cx_decide(desc.mode, desc.count, rchain_en);
    end

endmodule

// File: rtl/cx_bus_mux.sv
module cx_bus_mux
    import cx_pkg::*;
#(
    parameter int                SRC_W    = 4,
    parameter logic [WORD_W-1:0] VEC_BASE = 32'h0
) (
    input  cx_state_e         state,
    input  logic [1:0]        widx,
    input  logic [SRC_W-1:0]  src_id,
    input  logic [WORD_W-1:0] desc_ptr,
    input  cx_desc_t          desc,
    input  logic [WORD_W-1:0] data_q,
    output logic              req,
    output logic              we,
    output logic [WORD_W-1:0] addr,
    output logic [WORD_W-1:0] wdata
);

    logic [WORD_W-1:0] word_off;

    assign word_off = {28'd0, widx, 2'b00};

    always_comb begin
        req   = 1'b0;
        we    = 1'b0;
        addr  = '0;
        wdata = '0;
        case (state)
            ST_VEC: begin
                req  = 1'b1;
                addr = VEC_BASE + (WORD_W'(src_id) << 2);
            end
            ST_DESC: begin
                req  = 1'b1;
                addr = desc_ptr + word_off;
            end
            ST_SRD: begin
                req  = 1'b1;
                addr = desc.src;
            end
            ST_DWR: begin
                req   = 1'b1;
                we    = 1'b1;
                addr  = desc.dst;
                wdata = data_q;
            end
            ST_WB: begin
                req  = 1'b1;
                we   = 1'b1;
                addr = desc_ptr + word_off;
                case (widx)
                    2'd0:    wdata = desc.src;
                    2'd1:    wdata = desc.dst;
                    default: wdata = {desc.reload, desc.count};
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/chain_xfer_ctrl.sv
module chain_xfer_ctrl
    import cx_pkg::*;
#(
    parameter int          SRC_W    = 4,
    parameter logic [31:0] VEC_BASE = 32'h0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_valid,
    input  logic [SRC_W-1:0] act_src,
    input  logic             repeat_chain_en,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             busy,
    output logic             irq_pulse,
    output logic             flag_clr_pulse,
    output logic [SRC_W-1:0] flag_clr_src
);

    localparam logic [1:0] LAST_DESC_IDX = 2'(DESC_WDS - 1);
    localparam logic [1:0] LAST_WB_IDX   = 2'(WB_WDS - 1);

    cx_state_e         state;
    logic [1:0]        widx;
    logic [SRC_W-1:0]  src_q;
    logic [WORD_W-1:0] desc_ptr;
    logic [WORD_W-1:0] data_q;
    cx_outcome_t       oc_q;
    cx_outcome_t       oc_now;
    cx_desc_t          desc;
    logic              load_en;
    logic              upd_en;

    assign load_en = (state == ST_DESC) && mem_ack;
    assign upd_en  = (state == ST_DWR) && mem_ack;

    cx_desc_store u_store (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_idx  (widx),
        .load_word (mem_rdata),
        .upd_en    (upd_en),
        .desc      (desc)
    );

    cx_outcome u_outcome (
        .desc      (desc),
        .rchain_en (repeat_chain_en),
        .outcome   (oc_now)
    );

    cx_bus_mux #(
        .SRC_W    (SRC_W),
        .VEC_BASE (VEC_BASE)
    ) u_bus (
        .state    (state),
        .widx     (widx),
        .src_id   (src_q),
        .desc_ptr (desc_ptr),
        .desc     (desc),
        .data_q   (data_q),
        .req      (mem_req),
        .we       (mem_we),
        .addr     (mem_addr),
        .wdata    (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            widx     <= '0;
            src_q    <= '0;
            desc_ptr <= '0;
            data_q   <= '0;
            oc_q     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (act_valid) begin
                        src_q <= act_src;
                        state <= ST_VEC;
                    end
                end
                ST_VEC: begin
                    if (mem_ack) begin
                        desc_ptr <= mem_rdata;
                        widx     <= '0;
                        state    <= ST_DESC;
                    end
                end
                ST_DESC: begin
                    if (mem_ack) begin
                        if (widx == LAST_DESC_IDX) begin
                            widx  <= '0;
                            state <= ST_SRD;
                        end else begin
                            widx <= widx + 2'd1;
                        end
                    end
                end
                ST_SRD: begin
                    if (mem_ack) begin
                        data_q <= mem_rdata;
                        state  <= ST_DWR;
                    end
                end
                ST_DWR: begin
                    if (mem_ack) begin
                        oc_q  <= oc_now;
                        widx  <= '0;
                        state <= ST_WB;
                    end
                end
                ST_WB: begin
                    if (mem_ack) begin
                        if (widx == LAST_WB_IDX) begin
                            widx  <= '0;
                            state <= oc_q.chain ? ST_NEXT : ST_OUT;
                        end else begin
                            widx <= widx + 2'd1;
                        end
                    end
                end
                ST_NEXT: begin
                    desc_ptr <= desc_ptr + DESC_SPAN;
                    widx     <= '0;
                    state    <= ST_DESC;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy           = (state != ST_IDLE);
    assign irq_pulse      = (state == ST_OUT) && oc_q.irq;
    assign flag_clr_pulse = (state == ST_OUT) && oc_q.clr;
    assign flag_clr_src   = src_q;

endmodule

// File: rtl/cx_checker.sv
module cx_checker #(
    parameter int SRC_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             act_valid,
    input logic             busy,
    input logic             mem_req,
    input logic             mem_we,
    input logic [31:0]      mem_addr,
    input logic [31:0]      mem_wdata,
    input logic             mem_ack,
    input logic             irq_pulse,
    input logic             flag_clr_pulse,
    input logic [SRC_W-1:0] flag_clr_src
);

    // R10
    act_to_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (act_valid && !busy) |=> busy);

    // R10
    outcome_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse || flag_clr_pulse) |-> busy);

    // R10
    outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(irq_pulse && flag_clr_pulse));

    // R10
    outcome_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse || flag_clr_pulse) |=> (!busy && $stable(flag_clr_src)));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R11
    req_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

endmodule

bind chain_xfer_ctrl cx_checker #(.SRC_W(SRC_W)) u_cx_checker (
    .clk            (clk),
    .rst            (rst),
    .act_valid      (act_valid),
    .busy           (busy),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .mem_ack        (mem_ack),
    .irq_pulse      (irq_pulse),
    .flag_clr_pulse (flag_clr_pulse),
    .flag_clr_src   (flag_clr_src)
);

// File: tb/chain_xfer_ctrl_bench.sv
module chain_xfer_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        act_valid = 1'b0;
    logic [3:0]  act_src = '0;
    logic        repeat_chain_en = 1'b0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, irq_pulse, flag_clr_pulse;
    logic [3:0]  flag_clr_src;

    always #4 clk = ~clk;

    chain_xfer_ctrl #(.SRC_W(4), .VEC_BASE(32'h0)) u_chain_xfer_ctrl (
        .clk(clk), .rst(rst), .act_valid(act_valid), .act_src(act_src),
        .repeat_chain_en(repeat_chain_en), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .busy(busy), .irq_pulse(irq_pulse),
        .flag_clr_pulse(flag_clr_pulse), .flag_clr_src(flag_clr_src)
    );

    logic [31:0] mem [0:255];
    logic        bk_we = 1'b0;
    logic [31:0] bk_addr = '0;
    logic [31:0] bk_data = '0;

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:2]];
        end else begin
            mem_ack <= 1'b0;
        end
        if (bk_we) mem[bk_addr[9:2]] <= bk_data;
    end

    logic        cnt_clr = 1'b0;
    int          irq_n, clr_n, acc_n, viol_n;
    logic [3:0]  clr_src_l;
    logic        first_v, pend;
    logic [31:0] first_a, pend_a;

    always @(posedge clk) begin
        if (rst) begin
            viol_n <= 0;
            pend   <= 1'b0;
        end else begin
            if (pend && !(mem_req && mem_addr == pend_a)) viol_n <= viol_n + 1;
            pend   <= mem_req && !mem_ack;
            pend_a <= mem_addr;
        end
        if (cnt_clr) begin
            irq_n <= 0; clr_n <= 0; acc_n <= 0; first_v <= 1'b0;
        end else begin
            if (irq_pulse) irq_n <= irq_n + 1;
            if (flag_clr_pulse) begin
                clr_n     <= clr_n + 1;
                clr_src_l <= flag_clr_src;
            end
            if (mem_req && mem_ack) begin
                acc_n <= acc_n + 1;
                if (!first_v) begin
                    first_v <= 1'b1;
                    first_a <= mem_addr;
                end
            end
        end
    end

    int total = 0;
    int bad   = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] d);
        bk_we = 1'b1; bk_addr = a; bk_data = d;
        @(negedge clk);
        bk_we = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] cnt, input logic [31:0] mode);
        put(at, s); put(at + 4, d); put(at + 8, cnt); put(at + 12, mode);
    endtask

    function automatic logic [31:0] peek(input logic [31:0] a);
        return mem[a[9:2]];
    endfunction

    task automatic activate(input logic [3:0] src, input logic rch);
        repeat_chain_en = rch;
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        act_valid = 1'b1; act_src = src;
        @(negedge clk);
        act_valid = 1'b0;
        chk("R10 busy after activation", {31'd0, busy}, 32'd1);
        for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
        chk("R10 busy released", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R10 reset busy", {31'd0, busy}, 32'd0);
        chk("R10 reset pulses", {30'd0, irq_pulse, flag_clr_pulse}, 32'd0);
        chk("R11 reset req", {31'd0, mem_req}, 32'd0);
    endtask

    task automatic t_single_clr();
        put(32'h08, 32'h100);
        put_desc(32'h100, 32'h200, 32'h300, 32'h3, 32'h30);
        put(32'h200, 32'hA5A5_0001);
        activate(4'd2, 1'b0);
        chk("R1 first access is vector", first_a, 32'h08);
        chk("R2 data moved", peek(32'h300), 32'hA5A5_0001);
        chk("R2 src incremented", peek(32'h100), 32'h204);
        chk("R2 dst incremented", peek(32'h104), 32'h304);
        chk("R3 count written back", peek(32'h108), 32'h2);
        chk("R3 mode untouched", peek(32'h10C), 32'h30);
        chk("R7 clear when count nonzero", clr_n, 1);
        chk("R7 no irq", irq_n, 0);
        chk("R10 clear source id", {28'd0, clr_src_l}, 32'd2);
        chk("R11 access count", acc_n, 10);
    endtask

    task automatic t_single_irq();
        put(32'h14, 32'h120);
        put_desc(32'h120, 32'h210, 32'h310, 32'h1, 32'h20);
        put(32'h210, 32'h1234_5678);
        activate(4'd5, 1'b0);
        chk("R2 data moved fixed src", peek(32'h310), 32'h1234_5678);
        chk("R2 src held", peek(32'h120), 32'h210);
        chk("R3 count reached zero", peek(32'h128), 32'h0);
        chk("R7 irq at zero", irq_n, 1);
        chk("R7 no clear at zero", clr_n, 0);
    endtask

    task automatic t_chain_always();
        put(32'h04, 32'h140);
        put_desc(32'h140, 32'h220, 32'h320, 32'h5, 32'h31);
        put_desc(32'h150, 32'h224, 32'h324, 32'h1, 32'h30);
        put(32'h220, 32'h11); put(32'h224, 32'h22);
        activate(4'd1, 1'b0);
        chk("R4 first data", peek(32'h320), 32'h11);
        chk("R4 chained data", peek(32'h324), 32'h22);
        chk("R4 first count", peek(32'h148), 32'h4);
        chk("R4 single irq", irq_n, 1);
        chk("R4 no clear", clr_n, 0);
        chk("R11 chained access count", acc_n, 19);
    endtask

    task automatic t_cond_last();
        put(32'h0C, 32'h160);
        put_desc(32'h160, 32'h230, 32'h330, 32'h1, 32'h33);
        put_desc(32'h170, 32'h234, 32'h334, 32'h2, 32'h30);
        put(32'h230, 32'h33); put(32'h234, 32'h44); put(32'h334, 32'h0);
        activate(4'd3, 1'b0);
        chk("R5 chained at zero", peek(32'h334), 32'h44);
        chk("R5 outcome from next", clr_n, 1);
        chk("R5 no irq", irq_n, 0);
    endtask

    task automatic t_cond_nonzero(input logic isel);
        put(32'h10, 32'h180);
        put_desc(32'h180, 32'h240, 32'h340, 32'h3, isel ? 32'h37 : 32'h33);
        put_desc(32'h190, 32'h244, 32'h344, 32'h1, 32'h30);
        put(32'h240, 32'h55); put(32'h244, 32'h66); put(32'h344, 32'h0);
        activate(4'd4, 1'b0);
        chk("R6 first data moved", peek(32'h340), 32'h55);
        chk("R6 next not touched", peek(32'h344), 32'h0);
        chk("R6 count", peek(32'h188), 32'h2);
        chk("R6 irq by select", irq_n, {31'd0, isel});
        chk("R6 clear by select", clr_n, {31'd0, ~isel});
    endtask

    task automatic t_repeat();
        put(32'h18, 32'h1A0);
        put_desc(32'h1A0, 32'h208, 32'h350, 32'h0003_0001, 32'h18);
        put(32'h208, 32'h77);
        activate(4'd6, 1'b0);
        chk("R8 data moved", peek(32'h350), 32'h77);
        chk("R8 src restored", peek(32'h1A0), 32'h200);
        chk("R8 dst fixed", peek(32'h1A4), 32'h350);
        chk("R8 count reloaded", peek(32'h1A8), 32'h0003_0003);
        chk("R8 no irq at zero", irq_n, 0);
        chk("R8 clear", clr_n, 1);
    endtask

    task automatic t_repeat_chain(input logic rch);
        put(32'h1C, 32'h1C0);
        put_desc(32'h1C0, 32'h260, 32'h360, 32'h0002_0001, 32'h3B);
        put_desc(32'h1D0, 32'h264, 32'h364, 32'h1, 32'h30);
        put(32'h260, 32'h88); put(32'h264, 32'h99); put(32'h364, 32'h0);
        activate(4'd7, rch);
        chk("R9 first data", peek(32'h360), 32'h88);
        chk("R8 src restored in chain", peek(32'h1C0), 32'h25C);
        chk("R9 chain taken", peek(32'h364), rch ? 32'h99 : 32'h0);
        chk("R9 irq", irq_n, {31'd0, rch});
        chk("R9 clear", clr_n, {31'd0, ~rch});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single_clr();
        t_single_irq();
        t_chain_always();
        t_cond_last();
        t_cond_nonzero(1'b1);
        t_cond_nonzero(1'b0);
        t_repeat();
        t_repeat_chain(1'b1);
        t_repeat_chain(1'b0);
        chk("R11 held requests stable", viol_n, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule